// File: doc/BRIEF.md
# Predicated Vector Lane ALU

This block applies one integer operation to every element of a wide vector in a single registered step. Two source vectors, a prior destination vector, an 8-bit immediate and a packed predicate arrive together with a valid strobe. One cycle later the block presents the result vector with its own valid strobe. The operation can be add, subtract, reverse subtract, or copy of the immediate. The element width is chosen per request as 8, 16, 32 or 64 bits. The vector width is a parameter that is a multiple of 128 bits, from 128 to 2048.

The predicate carries one bit per byte of vector data. For each element, only the bit of the element's lowest byte decides whether the element is active. Inactive elements either keep the prior destination value (merging) or are written with zero (zeroing), as the mode input selects. Arithmetic wraps modulo the element width.

Output validity is tracked by a two-state machine. ST_EMPTY means no result is held and ST_FULL means a fresh result is on the outputs. Transition T_LOAD (any state to ST_FULL) is taken when `in_valid` is high at a clock edge. Transition T_DRAIN (any state to ST_EMPTY) is taken when `in_valid` is low. Reset forces ST_EMPTY.

Top module: `pred_vec_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `result` is all zeros.
- R2: A request with `in_valid` high appears on `result` with `out_valid` high at the next rising clock edge. A cycle with `in_valid` low drops `out_valid` at the next edge and leaves `result` unchanged.
- R3: With `zero_mode`=0 (merging), every byte of an inactive element equals the same byte of `dst_in`.
- R4: With `zero_mode`=1 (zeroing), every byte of an inactive element is zero.
- R5: `esize` encodes the element width as 0=8, 1=16, 2=32, 3=64 bits. Element k of width E bits occupies `[k*E +: E]`. The element is active exactly when `pred[k*E/8]` is 1, and all other predicate bits inside the element have no effect.
- R6: `op`=0 gives, for each active element, (a + b) mod 2^E.
- R7: `op`=1 gives, for each active element, (a − b) mod 2^E.
- R8: `op`=2 (reverse subtract) gives, for each active element, (b − a) mod 2^E.
- R9: `op`=3 writes `imm`, sign-extended from 8 bits to E bits, into each active element. `src_a` and `src_b` have no effect for this operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation: 0 add, 1 sub, 2 reverse sub, 3 copy immediate |
| esize | input | 2 | Element width code |
| zero_mode | input | 1 | 1 zeroes inactive elements, 0 merges them |
| pred | input | VLEN/8 | Packed predicate, one bit per byte |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| dst_in | input | VLEN | Prior destination value, used for merging |
| imm | input | 8 | Signed immediate for copy |
| out_valid | output | 1 | Result strobe |
| result | output | VLEN | Result vector |

## Verification
The bench builds the block with VLEN=256. That gives 32 byte lanes and a 32-bit predicate, so all four element widths have several elements per vector: 32 bytes, 16 halfwords, 8 words and 4 doublewords. At this width the 64-bit elements can carry across byte and word boundaries, and predicate bits above the lowest byte of an element can be set to show that they are ignored. Directed vectors hit wrap-around, all-inactive predicates in both modes and negative immediates. A long run of random requests interleaved with idle cycles is then compared against the behavioural model on every clock.

// File: rtl/pred_vec_alu_pkg.sv
package pred_vec_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_RSUB = 2'd2,
        OP_CPY  = 2'd3
    } alu_op_t;

    typedef enum logic [1:0] {
        ES_8  = 2'd0,
        ES_16 = 2'd1,
        ES_32 = 2'd2,
        ES_64 = 2'd3
    } elem_size_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/pred_vec_alu_lane_arith.sv
module pred_vec_alu_lane_arith
    import pred_vec_alu_pkg::*;
#(
    parameter int VLEN  = 256,
    parameter int EBITS = 8
) (
    input  alu_op_t           op,
    input  logic [VLEN-1:0]   src_a,
    input  logic [VLEN-1:0]   src_b,
    input  logic [7:0]        imm,
    output logic [VLEN-1:0]   res
);
    localparam int NELEM = VLEN / EBITS;

    logic [EBITS-1:0] imm_ext;
    assign imm_ext = EBITS'(signed'(imm));

    for (genvar k = 0; k < NELEM; k++) begin : g_elem
        logic [EBITS-1:0] ea, eb, er;
        assign ea = src_a[k*EBITS +: EBITS];
        assign eb = src_b[k*EBITS +: EBITS];
        always_comb begin
            unique case (op)
                OP_ADD:  er = ea + eb;
                OP_SUB:  er = ea - eb;
                OP_RSUB: er = eb - ea;
                OP_CPY:  er = imm_ext;
                default: er = '0;
            endcase
        end
        assign res[k*EBITS +: EBITS] = er;
    end

endmodule

// File: rtl/pred_vec_alu_pred_expand.sv
module pred_vec_alu_pred_expand
    import pred_vec_alu_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic [VLEN/8-1:0] pred,
    input  elem_size_t        esize,
    output logic [VLEN/8-1:0] byte_active
);
    localparam int NBYTES = VLEN / 8;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_comb begin
            unique case (esize)
                ES_8:    byte_active[i] = pred[i];
                ES_16:   byte_active[i] = pred[i - (i % 2)];
                ES_32:   byte_active[i] = pred[i - (i % 4)];
                ES_64:   byte_active[i] = pred[i - (i % 8)];
                default: byte_active[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pred_vec_alu.sv
module pred_vec_alu
    import pred_vec_alu_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [1:0]        esize,
    input  logic              zero_mode,
    input  logic [VLEN/8-1:0] pred,
    input  logic [VLEN-1:0]   src_a,
    input  logic [VLEN-1:0]   src_b,
    input  logic [VLEN-1:0]   dst_in,
    input  logic [7:0]        imm,
    output logic              out_valid,
    output logic [VLEN-1:0]   result
);
    localparam int NBYTES = VLEN / 8;

    alu_op_t    op_e;
    elem_size_t es_e;
    assign op_e = alu_op_t'(op);
    assign es_e = elem_size_t'(esize);

    logic [VLEN-1:0] arith_res [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        pred_vec_alu_lane_arith #(
            .VLEN  (VLEN),
            .EBITS (8 << g)
        ) u_arith (
            .op    (op_e),
            .src_a (src_a),
            .src_b (src_b),
            .imm   (imm),
            .res   (arith_res[g])
        );
    end

    logic [NBYTES-1:0] byte_active;

    pred_vec_alu_pred_expand #(
        .VLEN (VLEN)
    ) u_expand (
        .pred        (pred),
        .esize       (es_e),
        .byte_active (byte_active)
    );

    logic [VLEN-1:0] sel_res;
    assign sel_res = arith_res[esize];

    logic [VLEN-1:0] next_res;
    for (genvar i = 0; i < NBYTES; i++) begin : g_merge
        always_comb begin
            if (byte_active[i])
                next_res[i*8 +: 8] = sel_res[i*8 +: 8];
            else if (zero_mode)
                next_res[i*8 +: 8] = 8'h00;
            else
                next_res[i*8 +: 8] = dst_in[i*8 +: 8];
        end
    end

    out_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: st_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  st_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= next_res;
    end

    assign out_valid = (st_q == ST_FULL);

endmodule

// File: rtl/pred_vec_alu_chk.sv
module pred_vec_alu_chk #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [1:0]        esize,
    input logic              zero_mode,
    input logic [VLEN/8-1:0] pred,
    input logic [VLEN-1:0]   src_a,
    input logic [VLEN-1:0]   src_b,
    input logic [VLEN-1:0]   dst_in,
    input logic [7:0]        imm,
    input logic              out_valid,
    input logic [VLEN-1:0]   result
);

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r3_merge_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mode && !pred[0]) |=> result[7:0] == $past(dst_in[7:0]));

    a_r4_zero_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode && !pred[0]) |=> result[7:0] == 8'h00);

    a_r6_add_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && esize == 2'd0 && pred[0])
        |=> result[7:0] == 8'($past(src_a[7:0]) + $past(src_b[7:0])));

    a_r9_copy_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd3 && esize == 2'd0 && pred[0])
        |=> result[7:0] == $past(imm));

endmodule

bind pred_vec_alu pred_vec_alu_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .esize     (esize),
    .zero_mode (zero_mode),
    .pred      (pred),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_in    (dst_in),
    .imm       (imm),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pred_vec_alu_tb_top.sv
`timescale 1ns/1ps
module pred_vec_alu_tb_top;
    localparam int VL = 256;
    localparam int NB = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op = '0;
    logic [1:0]    esize = '0;
    logic          zero_mode = 1'b0;
    logic [NB-1:0] pred = '0;
    logic [VL-1:0] src_a = '0;
    logic [VL-1:0] src_b = '0;
    logic [VL-1:0] dst_in = '0;
    logic [7:0]    imm = '0;
    logic          out_valid;
    logic [VL-1:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic          exp_valid = 1'b0;
    logic [VL-1:0] exp_result = '0;

    always #2.5 clk = ~clk;

    pred_vec_alu #(.VLEN(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
        .zero_mode(zero_mode), .pred(pred), .src_a(src_a), .src_b(src_b),
        .dst_in(dst_in), .imm(imm), .out_valid(out_valid), .result(result)
    );

    function automatic logic [VL-1:0] model(input logic [1:0] o, input logic [1:0] es,
            input logic zm, input logic [NB-1:0] p, input logic [VL-1:0] a,
            input logic [VL-1:0] b, input logic [VL-1:0] d, input logic [7:0] im);
        logic [VL-1:0] r;
        int ebytes, ebits;
        logic [63:0] mask, ea, eb, ed, v;
        r = '0;
        ebytes = 1 << es;
        ebits = ebytes * 8;
        mask = (ebits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ebits) - 64'd1);
        for (int k = 0; k < NB / ebytes; k++) begin
            ea = 64'(a >> (k * ebits)) & mask;
            eb = 64'(b >> (k * ebits)) & mask;
            ed = 64'(d >> (k * ebits)) & mask;
            if (p[k * ebytes]) begin
                case (o)
                    2'd0: v = ea + eb;
                    2'd1: v = ea - eb;
                    2'd2: v = eb - ea;
                    default: v = {{56{im[7]}}, im};
                endcase
            end else begin
                v = zm ? 64'd0 : ed;
            end
            r = r | (VL'(v & mask) << (k * ebits));
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int j = 0; j < VL / 32; j++) v[j*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic compare(input string req);
        checks++;
        if (out_valid !== exp_valid || result !== exp_result) begin
            errors++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     req, out_valid, result, exp_valid, exp_result);
        end
    endtask

    // inputs are set at a negedge; one clock passes; model updates; check at next negedge
    task automatic step(input string req);
        @(posedge clk);
        #1;
        if (in_valid) begin
            exp_valid  = 1'b1;
            exp_result = model(op, esize, zero_mode, pred, src_a, src_b, dst_in, imm);
        end else begin
            exp_valid = 1'b0;
        end
        @(negedge clk);
        compare(req);
    endtask

    task automatic req(input logic [1:0] o, input logic [1:0] es, input logic zm,
            input logic [NB-1:0] p, input logic [VL-1:0] a, input logic [VL-1:0] b,
            input logic [VL-1:0] d, input logic [7:0] im, input string tag);
        in_valid = 1'b1; op = o; esize = es; zero_mode = zm; pred = p;
        src_a = a; src_b = b; dst_in = d; imm = im;
        step(tag);
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        src_a = rnd_vec(); src_b = rnd_vec(); dst_in = rnd_vec();
        step(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] ones, d0;
        ones = '1;
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset release");

        // R6: byte add with wrap 0xFF+1
        req(2'd0, 2'd0, 1'b0, '1, ones, {(NB){8'h01}}, '0, 8'h00, "R6 byte add wrap");
        // R6 with 64-bit carries across bytes
        req(2'd0, 2'd3, 1'b0, '1, rnd_vec(), rnd_vec(), '0, 8'h00, "R6 dword add");
        // R7: halfword subtract, merging, alternating predicate R3
        req(2'd1, 2'd1, 1'b0, {(NB/4){4'b0011}}, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00,
            "R7 R3 half sub merge");
        // R8: reverse subtract on words, zeroing R4
        req(2'd2, 2'd2, 1'b1, {(NB/8){8'h0F}}, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00,
            "R8 R4 word rsub zero");
        // R9: copy negative immediate into dwords, zeroing, sources random
        req(2'd3, 2'd3, 1'b1, {(NB/8){8'h01}}, rnd_vec(), rnd_vec(), rnd_vec(), 8'hFF,
            "R9 dword copy 0xFF");
        // R9: copy positive immediate bytes, merging
        req(2'd3, 2'd0, 1'b0, {(NB/2){2'b01}}, rnd_vec(), rnd_vec(), rnd_vec(), 8'h5A,
            "R9 R3 byte copy merge");
        // R5: only non-lowest bits set in each dword: all inactive, merge keeps dst
        d0 = rnd_vec();
        req(2'd0, 2'd3, 1'b0, {(NB/8){8'hFE}}, rnd_vec(), rnd_vec(), d0, 8'h00,
            "R5 R3 ignored pred bits merge");
        // R5: same in zeroing: all zero
        req(2'd1, 2'd2, 1'b1, {(NB/4){4'hE}}, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00,
            "R5 R4 ignored pred bits zero");
        // R5: lowest bits set, others clear: all active
        req(2'd2, 2'd1, 1'b1, {(NB/2){2'b01}}, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00,
            "R5 R8 half rsub lowest bits");
        // R2: idle cycles hold result, drop valid
        idle("R2 idle hold 1");
        idle("R2 idle hold 2");
        // R2: back-to-back
        req(2'd0, 2'd2, 1'b0, '1, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00, "R2 R6 back to back a");
        req(2'd1, 2'd0, 1'b0, '1, rnd_vec(), rnd_vec(), rnd_vec(), 8'h00, "R2 R7 back to back b");
        // R7 wrap: 0 - 1 in dwords
        req(2'd1, 2'd3, 1'b0, '1, '0, {(VL/64){64'd1}}, '0, 8'h00, "R7 dword sub wrap");

        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0) idle("R2 random idle");
            else req(2'($urandom), 2'($urandom), 1'($urandom), NB'(rnd_vec()),
                     rnd_vec(), rnd_vec(), rnd_vec(), 8'($urandom),
                     "R3 R4 R5 R6 R7 R8 R9 random");
        end
        idle("R2 final idle");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule